// File: doc/BRIEF.md
# Two-Stage Digital Pulse-Width Modulator

This block turns an n-bit duty word into a pulse train. Its period is 2^n cycles of a single fine clock. The duty word is split into two parts. The upper NC bits pick the coarse slot in which the pulse ends. Each coarse slot lasts 2^ND fine cycles and is counted by a slot counter. The lower ND bits pick one output of a short register chain, and that chain delays the coarse match by 0 to 2^ND-1 fine cycles. The falling edge therefore comes from a small slot compare plus a 2^ND-way tap multiplexer, and no comparator of the full n-bit width is needed.

The output goes high at the start of each period unless the duty word is zero. It drops when the selected delayed edge arrives. The block samples the duty word only at the period boundary, so a caller may change it at any time and the new value applies from the next period. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer before the counters start.

Top module: `hybrid_pwm`

## Requirements
- R1: With a nonzero duty word, the output rises once every 2^(NC+ND) fine cycles (16 with the defaults). Each period starts in the same phase.
- R2: For a duty word D between 1 and 2^(NC+ND)-2, the output is high for exactly D consecutive fine cycles of each period and low for the rest.
- R3: A duty word of 0 keeps the output low for the whole period, including the first cycle of the period.
- R4: The duty word is captured only in the first cycle of a period. A change at any other time does not alter the current pulse and applies from the next period.
- R5: The falling edge falls in coarse slot duty[NC+ND-1:ND], at fine offset duty[ND-1:0] within that slot. Every period has at most one falling edge.
- R6: The largest duty word (all ones) gives a pulse of 2^(NC+ND)-1 cycles followed by exactly one low cycle.
- R7: While the reset input is low, the output is low at once. After release, the output stays low for two rising edges. The first period's decision is registered on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fine clock; one cycle is one duty step |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_i | input | NC+ND | Duty word, high time in fine cycles |
| pwm_o | output | 1 | Modulated output |

## Verification
Suppose the slot counter or the fine counter held a wrong value. The pulse would then end in the wrong slot or at the wrong offset, and this shows at the output within one period as a high time that is off by a multiple of 2^ND or by a few fine cycles. If the delay chain failed, the pulse would keep running into the next period or end one or two cycles late. If the duty register captured at the wrong time, a mid-period change of the duty word would shorten or stretch the pulse in progress. The bench compares the output against a behavioural model on every cycle, so each of these faults is caught in the first period it affects.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;
  // Default split of the duty word: coarse (slot) bits and fine (tap) bits.
  localparam int unsigned HPWM_COARSE_BITS = 2;
  localparam int unsigned HPWM_FINE_BITS   = 2;

  // Number of fine cycles in one full switching period.
  function automatic int unsigned hpwm_period(input int unsigned nc, input int unsigned nd);
    return 32'd1 << (nc + nd);
  endfunction
endpackage

// File: rtl/hpwm_rst_sync.sv
module hpwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign run_o = sync_q[1];
endmodule

// File: rtl/hpwm_slot_timer.sv
module hpwm_slot_timer #(
  parameter int unsigned NC = 2,
  parameter int unsigned ND = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [ND-1:0] fine_o,
  output logic [NC-1:0] slot_o,
  output logic          slot_first_o,
  output logic          period_start_o
);
  localparam logic [ND-1:0] FINE_LAST = '1;

  logic [ND-1:0] fine_q, fine_d;
  logic [NC-1:0] slot_q, slot_d;

  always_comb begin
    fine_d = fine_q;
    slot_d = slot_q;
    if (run_i) begin
      fine_d = fine_q + 1'b1;
      if (fine_q == FINE_LAST) slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q <= '0;
      slot_q <= '0;
    end else begin
      fine_q <= fine_d;
      slot_q <= slot_d;
    end
  end

  assign fine_o         = fine_q;
  assign slot_o         = slot_q;
  assign slot_first_o   = run_i && (fine_q == '0);
  assign period_start_o = slot_first_o && (slot_q == '0);
endmodule

// File: rtl/hpwm_tap_line.sv
module hpwm_tap_line #(
  parameter int unsigned ND = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               edge_i,
  input  logic [ND-1:0]      sel_i,
  output logic [(1<<ND)-1:0] taps_o,
  output logic               tap_o
);
  localparam int unsigned TAPS = 1 << ND;

  logic [TAPS-2:0] chain_q, chain_d;

  generate
    if (TAPS == 2) begin : g_single
      always_comb chain_d = edge_i;
    end else begin : g_shift
      always_comb chain_d = {chain_q[TAPS-3:0], edge_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    chain_q <= '0;
    else if (run_i) chain_q <= chain_d;
  end

  assign taps_o = {chain_q, edge_i};
  assign tap_o  = taps_o[sel_i];
endmodule

// File: rtl/hybrid_pwm.sv
module hybrid_pwm
  import hpwm_pkg::*;
#(
  parameter int unsigned NC = HPWM_COARSE_BITS,
  parameter int unsigned ND = HPWM_FINE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NC+ND-1:0] duty_i,
  output logic             pwm_o
);
  localparam int unsigned N    = NC + ND;
  localparam int unsigned TAPS = 1 << ND;

  logic            run;
  logic [ND-1:0]   fine;
  logic [NC-1:0]   slot;
  logic            slot_first;
  logic            period_start;
  logic [N-1:0]    duty_q, duty_d, duty_eff;
  logic            coarse_hit;
  logic [TAPS-1:0] taps;
  logic            tap_hit;
  logic            pwm_q, pwm_d;

  hpwm_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  hpwm_slot_timer #(.NC(NC), .ND(ND)) u_timer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (run),
    .fine_o         (fine),
    .slot_o         (slot),
    .slot_first_o   (slot_first),
    .period_start_o (period_start)
  );

  // Duty in force this cycle: the live word at the boundary, else the held copy.
  assign duty_eff   = period_start ? duty_i : duty_q;
  assign coarse_hit = slot_first && (slot == duty_eff[N-1:ND]);

  hpwm_tap_line #(.ND(ND)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .edge_i (coarse_hit),
    .sel_i  (duty_eff[ND-1:0]),
    .taps_o (taps),
    .tap_o  (tap_hit)
  );

  always_comb begin
    duty_d = duty_q;
    if (period_start) duty_d = duty_i;
    pwm_d = 1'b0;
    if (run) pwm_d = (period_start | pwm_q) & ~tap_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/hpwm_checker.sv
module hpwm_checker #(
  parameter int unsigned N    = 4,
  parameter int unsigned TAPS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    duty_i,
  input logic            pwm_o,
  input logic            period_start,
  input logic [TAPS-1:0] taps,
  input logic [N-1:0]    duty_q
);
  // R1: a rising edge follows only a period boundary
  p_rise_at_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(period_start));

  // R2: a falling edge is caused by a delayed coarse match
  p_fall_from_tap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_o) |-> $past(taps != '0));

  // R3: zero duty gives no pulse at the boundary
  p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start && duty_i == '0) |=> !pwm_o);

  // R4: held duty changes only at the boundary
  p_duty_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start |=> $stable(duty_q));

  // R5: at most one delayed edge in flight
  p_single_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(taps));

  // R6: full-scale duty starts high
  p_full_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start && duty_i == '1) |=> pwm_o);

  // R7: reset forces the output low
  p_reset_low_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !pwm_o);
endmodule

bind hybrid_pwm hpwm_checker #(.N(N), .TAPS(TAPS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .duty_i       (duty_i),
  .pwm_o        (pwm_o),
  .period_start (period_start),
  .taps         (taps),
  .duty_q       (duty_q)
);

// File: tb/test_hybrid_pwm.sv
`timescale 1ns/1ps
module test_hybrid_pwm;
  localparam int NBITS  = 4;
  localparam int PERIOD = 1 << NBITS;
  localparam int MAXD   = PERIOD - 1;

  logic             clk;
  logic             rst_n;
  logic [NBITS-1:0] duty;
  logic             pwm;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  int pd     = 0;
  int cur    = 0;
  bit done   = 0;

  hybrid_pwm i_hybrid_pwm (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .duty_i (duty),
    .pwm_o  (pwm)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pwm=%0b expected %0b (edge %0d)", req, act, exp, edges);
    end
  endtask

  // One fine cycle: model the edge just passed, compare, then drive the next word.
  task automatic tick(input int nxt);
    int t;
    logic exp;
    string req;
    @(negedge clk);
    edges++;
    if (edges < 3) begin
      exp = 1'b0;
      req = "R7";
    end else begin
      t = (edges - 3) % PERIOD;
      if (t == 0) pd = cur;
      exp = (t < pd);
      if (edges == 3)                req = "R7";
      else if (cur != pd && t != 0)  req = "R4";
      else if (pd == 0)              req = "R3";
      else if (pd == MAXD)           req = "R6";
      else if (t == pd)              req = "R5";
      else if (t == 0)               req = "R1";
      else                           req = "R2";
    end
    check(req, pwm, exp);
    cur  = nxt;
    duty = NBITS'(nxt);
  endtask

  task automatic hold(input int d, input int n);
    for (int i = 0; i < n; i++) tick(d);
  endtask

  initial begin
    rst_n = 1'b0;
    duty  = '0;
    #1;
    check("R7", pwm, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", pwm, 1'b0);
    cur = 5;
    duty = 4'd5;
    rst_n = 1'b1;
    edges = 0;
    hold(5, 2 * PERIOD + 2);
    // sweep of duty values, each held over whole periods
    hold(1, 2 * PERIOD);
    hold(8, 2 * PERIOD);
    hold(10, 2 * PERIOD);
    hold(0, 2 * PERIOD);
    hold(MAXD, 2 * PERIOD);
    hold(4, 2 * PERIOD);
    hold(3, 2 * PERIOD);
    hold(14, 2 * PERIOD);
    // mid-period changes (R4): toggle the word every few cycles
    for (int p = 0; p < 6; p++) begin
      hold(2, 3);
      hold(13, 5);
      hold(0, 4);
      hold(9, 7);
    end
    hold(6, 2 * PERIOD);
    // asynchronous reset in the middle of a pulse (R7)
    hold(12, 5);
    #1.3 rst_n = 1'b0;
    #0.5;
    check("R7", pwm, 1'b0);
    @(negedge clk);
    check("R7", pwm, 1'b0);
    cur = 7;
    duty = 4'd7;
    rst_n = 1'b1;
    edges = 0;
    pd = 0;
    hold(7, 3 * PERIOD);
    hold(11, 2 * PERIOD);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule